// File: doc/BRIEF.md
# Interval Timer with Register Bus

A down-counting interval timer controlled through six word-wide registers on a simple write-and-read bus. Software writes a period as two 16-bit halves, chooses one-shot or repeating operation, and issues start and stop commands. A write to either snapshot register freezes the live count into both snapshot halves, so the two halves read back as one coherent value. A timeout flag records each expiry and drives a level interrupt when the interrupt enable is set.

The register index is the byte address shifted right by two. Index 0 is status (bit 0 timeout, bit 1 running). Index 1 is control (bit 0 interrupt enable, bit 1 continuous, bit 2 start command, bit 3 stop command). Indices 2 and 3 hold the period low and high halves. Indices 4 and 5 hold the snapshot low and high halves. Reads are combinational from the addressed register. A write is taken on the rising clock edge while `bus_wr` is high. The bus has no handshake: every access completes in its own cycle.

Top module: `ivl_timer`

## Requirements
- R1: After reset, indices 0 to 5 all read zero, `irq_o` is low, the timer is stopped and the counter holds all ones, so a snapshot taken then reads 0xFFFF in both halves.
- R2: Indices 6 and 7 read zero, and writes to them change no register.
- R3: Reading control returns only bit 0 (interrupt enable) and bit 1 (continuous). Bits 2 (start) and 3 (stop) always read zero.
- R4: Any write to status clears the timeout flag, whatever the data. If that write falls in the cycle of an expiry, the flag stays clear.
- R5: Start (control bit 2) sets the running flag only when the timer is idle. Stop (control bit 3) halts the timer and holds the count. When both bits are in one write, start is applied first and stop second, so the timer ends up stopped.
- R6: A write to period low (index 2) or period high (index 3) stores only data bits 15:0. It also halts the timer and loads the counter with the new full period {high, low}.
- R7: A write to index 4 or 5 captures the current count, before that cycle's update. Count bits 15:0 go to snapshot low and bits 31:16 go to snapshot high.
- R8: In one-shot mode (control bit 1 = 0), the cycle in which the running counter is at zero is an expiry. The next cycle has the timeout flag set, the running flag clear and the counter reloaded with the period and held there.
- R9: In continuous mode (control bit 1 = 1), an expiry sets the timeout flag and reloads the period, and the timer keeps running. The interval is period+1 cycles.
- R10: `irq_o` is high exactly when the timeout flag and the interrupt enable are both set.
- R11: While running, the counter drops by one on each clock. While stopped, it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address; register index is bits 4:2 |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| irq_o | output | 1 | Level interrupt: timeout flag AND interrupt enable |

## Verification
The assertions take for granted that `bus_addr`, `bus_wr` and `bus_wdata` are stable across each rising edge and change only between edges. They also assume that at most one register is written per cycle, since the bus carries a single address. The stimulus drives every bus signal on the falling edge and reads back half a cycle later. It issues at most one write per cycle, so every write lands on a known edge. The counter checks then rely on the expiry, stop and snapshot edges that were worked out for that edge.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int REG_STATUS = 0;
  localparam int REG_CTRL   = 1;
  localparam int REG_PER_LO = 2;
  localparam int REG_PER_HI = 3;
  localparam int REG_SNP_LO = 4;
  localparam int REG_SNP_HI = 5;

  localparam int ST_TIMEOUT = 0;
  localparam int ST_RUNNING = 1;

  localparam int CT_IRQ_EN  = 0;
  localparam int CT_CONT    = 1;
  localparam int CT_START   = 2;
  localparam int CT_STOP    = 3;
endpackage

// File: rtl/ivl_timer_counter.sv
module ivl_timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             cont_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign cnt_o    = cnt_q;
  assign run_o    = run_q;
  assign expire_o = run_q && (cnt_q == '0) && !load_i && !stop_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '1;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= 1'b0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else begin
      if (start_i && !run_q) run_q <= 1'b1;
      if (run_q) begin
        if (cnt_q == '0) begin
          cnt_q <= period_i;
          if (!cont_i) run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R11
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load_i && !stop_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_i) |=> $stable(cnt_q));
  // R8
  oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !cont_i) |=> (!run_q && cnt_q == $past(period_i)));
  // R9
  cont_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && cont_i) |=> (run_q && cnt_q == $past(period_i)));
  // R6
  load_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (!run_q && cnt_q == $past(load_val_i)));
  // R5
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i && !load_i && !run_q) |=> run_q);
  // R5
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !load_i) |=> (!run_q && $stable(cnt_q)));
endmodule

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs
  import ivl_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              run_i,
  input  logic              expire_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              cont_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int HALF_W = CNT_W / 2;

  logic [IDX_W-1:0]  idx;
  logic              st_wr, ct_wr, pl_wr, ph_wr, sn_wr;
  logic              to_q, ie_q, cont_q;
  logic [HALF_W-1:0] per_lo_q, per_hi_q, snp_lo_q, snp_hi_q;
  logic [HALF_W-1:0] wd_half;

  assign idx     = addr_i[ADDR_W-1:2];
  assign wd_half = wdata_i[HALF_W-1:0];
  assign st_wr   = wr_i && (idx == IDX_W'(REG_STATUS));
  assign ct_wr   = wr_i && (idx == IDX_W'(REG_CTRL));
  assign pl_wr   = wr_i && (idx == IDX_W'(REG_PER_LO));
  assign ph_wr   = wr_i && (idx == IDX_W'(REG_PER_HI));
  assign sn_wr   = wr_i && ((idx == IDX_W'(REG_SNP_LO)) || (idx == IDX_W'(REG_SNP_HI)));

  assign start_o    = ct_wr && wdata_i[CT_START];
  assign stop_o     = ct_wr && wdata_i[CT_STOP];
  assign load_o     = pl_wr || ph_wr;
  assign load_val_o = {ph_wr ? wd_half : per_hi_q, pl_wr ? wd_half : per_lo_q};
  assign period_o   = {per_hi_q, per_lo_q};
  assign cont_o     = cont_q;
  assign irq_o      = to_q && ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_q     <= 1'b0;
      ie_q     <= 1'b0;
      cont_q   <= 1'b0;
      per_lo_q <= '0;
      per_hi_q <= '0;
      snp_lo_q <= '0;
      snp_hi_q <= '0;
    end else begin
      if (st_wr)         to_q <= 1'b0;
      else if (expire_i) to_q <= 1'b1;
      if (ct_wr) begin
        ie_q   <= wdata_i[CT_IRQ_EN];
        cont_q <= wdata_i[CT_CONT];
      end
      if (pl_wr) per_lo_q <= wd_half;
      if (ph_wr) per_hi_q <= wd_half;
      if (sn_wr) begin
        snp_lo_q <= cnt_i[HALF_W-1:0];
        snp_hi_q <= cnt_i[CNT_W-1:HALF_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx)
      IDX_W'(REG_STATUS): begin
        rdata_o[ST_TIMEOUT] = to_q;
        rdata_o[ST_RUNNING] = run_i;
      end
      IDX_W'(REG_CTRL): begin
        rdata_o[CT_IRQ_EN] = ie_q;
        rdata_o[CT_CONT]   = cont_q;
      end
      IDX_W'(REG_PER_LO): rdata_o = DATA_W'(per_lo_q);
      IDX_W'(REG_PER_HI): rdata_o = DATA_W'(per_hi_q);
      IDX_W'(REG_SNP_LO): rdata_o = DATA_W'(snp_lo_q);
      IDX_W'(REG_SNP_HI): rdata_o = DATA_W'(snp_hi_q);
      default:            rdata_o = '0;
    endcase
  end

  // R4
  to_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> !to_q);
  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && !st_wr && (ie_q || (ct_wr && wdata_i[CT_IRQ_EN])) && !(ct_wr && !wdata_i[CT_IRQ_EN])) |=> irq_o);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_wr && !wdata_i[CT_IRQ_EN]) |=> !irq_o);
  // R7
  snap_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sn_wr |=> ({snp_hi_q, snp_lo_q} == $past(cnt_i)));
  // R2
  high_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && idx > IDX_W'(REG_SNP_HI)) |=> ($stable(ie_q) && $stable(cont_q) && $stable(per_lo_q) && $stable(per_hi_q) && $stable(snp_lo_q) && $stable(snp_hi_q)));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic             start_s, stop_s, load_s, cont_s, run_s, expire_s;
  logic [CNT_W-1:0] load_val_s, period_s, cnt_s;

  ivl_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (bus_addr),
    .wr_i       (bus_wr),
    .wdata_i    (bus_wdata),
    .cnt_i      (cnt_s),
    .run_i      (run_s),
    .expire_i   (expire_s),
    .start_o    (start_s),
    .stop_o     (stop_s),
    .load_o     (load_s),
    .load_val_o (load_val_s),
    .period_o   (period_s),
    .cont_o     (cont_s),
    .rdata_o    (bus_rdata),
    .irq_o      (irq_o)
  );

  ivl_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_s),
    .stop_i     (stop_s),
    .load_i     (load_s),
    .load_val_i (load_val_s),
    .period_i   (period_s),
    .cont_i     (cont_s),
    .cnt_o      (cnt_s),
    .run_o      (run_s),
    .expire_o   (expire_s)
  );
endmodule

// File: tb/tb_ivl_timer.sv
module tb_ivl_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ivl_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [3:0]  widx;
    logic [31:0] wdat;
    logic [3:0]  ridx;
    logic [31:0] rexp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 32'hABCD_1234, 4'd2, 32'h0000_1234, 8'd6},  // R6 low half only
    '{4'd3, 32'hFFFF_0001, 4'd3, 32'h0000_0001, 8'd6},  // R6 high half only
    '{4'd1, 32'h0000_000F, 4'd1, 32'h0000_0003, 8'd3},  // R3 cmd bits read 0
    '{4'd1, 32'h0000_000F, 4'd0, 32'h0000_0000, 8'd5},  // R5 start+stop idle
    '{4'd6, 32'h0000_FFFF, 4'd6, 32'h0000_0000, 8'd2},  // R2 idx6 reads 0
    '{4'd7, 32'h0000_0000, 4'd1, 32'h0000_0003, 8'd2},  // R2 ctrl untouched
    '{4'd1, 32'h0000_0004, 4'd1, 32'h0000_0000, 8'd3},  // R3 start not stored
    '{4'd7, 32'h0000_0000, 4'd0, 32'h0000_0002, 8'd5},  // R5 now running
    '{4'd2, 32'h0000_0005, 4'd0, 32'h0000_0000, 8'd6},  // R6 halts
    '{4'd3, 32'h0000_0000, 4'd3, 32'h0000_0000, 8'd6}   // R6 high cleared
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    bus_addr  = 5'(idx << 2);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    bus_addr = 5'(idx << 2);
    #1;
    check(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 6; i++) rd(i, 32'h0, "R1 reset read");
    check("R1 irq low", {31'b0, irq_o}, 32'h0);
    wr(4, 32'h0);
    rd(4, 32'h0000_FFFF, "R1 R7 reset snap lo");
    rd(5, 32'h0000_FFFF, "R1 R7 reset snap hi");

    for (int i = 0; i < NV; i++) begin
      wr(int'(VEC[i].widx), VEC[i].wdat);
      bus_addr = 5'({1'b0, VEC[i].ridx} << 2);
      #1;
      checks++;
      if (bus_rdata !== VEC[i].rexp) begin
        failures++;
        $display("FAIL R%0d vector %0d actual=0x%08h expected=0x%08h",
                 VEC[i].req, i, bus_rdata, VEC[i].rexp);
      end
      @(negedge clk);
    end

    // R6 R7 period load visible through snapshot
    wr(5, 32'h0);
    rd(4, 32'h5, "R6 R7 loaded snap lo");
    rd(5, 32'h0, "R6 R7 loaded snap hi");

    // R9 continuous, period 4
    wr(2, 32'h4);
    wr(0, 32'h0);
    wr(1, 32'h6);
    idle(6);
    rd(0, 32'h3, "R9 timeout and still running");
    wr(4, 32'h0);
    rd(4, 32'h2, "R9 reload count");
    wr(4, 32'h0);
    rd(4, 32'h0, "R11 decrement per clock");
    check("R10 irq masked", {31'b0, irq_o}, 32'h0);
    wr(1, 32'h3);
    check("R10 irq with enable", {31'b0, irq_o}, 32'h1);
    wr(0, 32'hFFFF_FFFF);
    check("R4 R10 status clear drops irq", {31'b0, irq_o}, 32'h0);
    wr(1, 32'h8);
    rd(0, 32'h0, "R5 stop halts");
    idle(2);
    wr(4, 32'h0);
    rd(4, 32'h1, "R11 hold while stopped");

    // R8 one-shot, period 2
    wr(2, 32'h2);
    wr(0, 32'h0);
    wr(1, 32'h5);
    idle(4);
    rd(0, 32'h1, "R8 timeout and stopped");
    check("R10 irq one-shot", {31'b0, irq_o}, 32'h1);
    wr(4, 32'h0);
    rd(4, 32'h2, "R8 reloaded and held");
    wr(0, 32'h0);
    check("R4 clear with zero data", {31'b0, irq_o}, 32'h0);

    // R4 clear coinciding with expiry
    wr(1, 32'h5);
    idle(2);
    wr(0, 32'h0);
    rd(0, 32'h0, "R4 clear beats expiry");
    check("R4 irq stays low", {31'b0, irq_o}, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule